// File: doc/BRIEF.md
# Vector Element Extract-to-Scalar Unit

This unit decodes and executes a single move instruction that copies one unsigned element out of a 128-bit vector register into a scalar general-purpose register, zero-extending the element to a 32-bit or 64-bit result. A 5-bit immediate field carries both the element size and the element index. The lowest set bit of its low four bits gives the size, and the bits above that bit give the index.

The unit is one registered pipeline stage. Each cycle it takes an instruction word, the vector operand fetched from the register named by the instruction's source field, and two permission inputs from the surrounding core. One cycle later it presents a destination register number, write data, a write strobe, a 32-bit-write marker, and the undefined-instruction and trap indications. The source field is also brought out combinationally, so the vector register file read can be addressed in the same cycle.

Top module: `vext_to_scalar`

## Requirements
- R1: An instruction word matches only when bit 31 is 0, bits 29:21 are 001110000 and bits 15:10 are 001111. When the word does not match, out_valid, out_undef, out_trap, out_wen, out_narrow, out_rd and out_wdata are all zero in the next cycle.
- R2: The element width is 8, 16, 32 or 64 bits when the lowest set bit of imm5[3:0] (insn bits 19:16) is at position 0, 1, 2 or 3 respectively.
- R3: The element index is imm5 bits 4 down to (size position + 1). The element is taken from operand bits starting at index times element width. Only the low 64 operand bits are visible when imm5[4] is 0, and all 128 bits are visible when imm5[4] is 1.
- R4: When imm5[3:0] is 0000, out_undef is 1 and out_wen is 0.
- R5: When Q (insn bit 30) is 1, any element narrower than 64 bits is undefined. When Q is 0, a 64-bit element is undefined. In both cases out_undef is 1 and out_wen is 0.
- R6: The element is zero-extended. For Q = 0, out_narrow is 1 and out_wdata[63:32] is zero. For Q = 1, out_narrow is 0 and all 64 bits carry the element.
- R7: Index 0 requires fp_ok, and a nonzero index requires simd_ok. If the required input is low, out_trap is 1, out_wen is 0 and out_wdata is zero.
- R8: out_undef and out_trap are never both 1. When the encoding is undefined, out_undef wins regardless of fp_ok and simd_ok.
- R9: Every accepted instruction produces out_valid exactly one cycle after in_valid, whatever the data, with out_rd equal to insn bits 4:0. With in_valid low, out_valid is low in the next cycle.
- R10: A synchronous active-high reset clears out_valid, out_undef, out_trap, out_wen and out_narrow at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and operand are valid this cycle |
| insn | input | 32 | Instruction word |
| vec_opnd | input | 128 | Contents of the source vector register |
| fp_ok | input | 1 | Floating-point access permitted |
| simd_ok | input | 1 | Combined floating-point and SIMD access permitted |
| src_vreg | output | 5 | Source vector register number (combinational from insn) |
| out_valid | output | 1 | Registered result is valid |
| out_rd | output | 5 | Destination scalar register number |
| out_wdata | output | 64 | Zero-extended write data |
| out_wen | output | 1 | Scalar register write enable |
| out_narrow | output | 1 | Write is a 32-bit write |
| out_undef | output | 1 | Undefined instruction |
| out_trap | output | 1 | Access trapped by permission check |

## Verification
On every cycle the assertions check the following: undefined and trap are mutually exclusive, neither flag ever comes with a write, a 32-bit write always has a clear upper half, idle cycles produce no valid output, and reserved or wrongly-paired size/width encodings at the ports always come back as undefined. Only the bench's scenarios can show which lane is picked for each size and index, the boundary indices into the upper 64 operand bits, and the choice between the two permission inputs by index. They also cover the exact write data, reset in the middle of traffic, and back-to-back issue.

// File: rtl/vext_pkg.sv
package vext_pkg;

   typedef enum logic [1:0] {
      ESZ_8  = 2'd0,
      ESZ_16 = 2'd1,
      ESZ_32 = 2'd2,
      ESZ_64 = 2'd3
   } esz_e;

   typedef struct packed {
      logic       hit;       // opcode pattern matched
      logic       bad_enc;   // reserved or illegal size/width pairing
      logic       narrow;    // 32-bit destination
      esz_e       size;
      logic [3:0] lane;      // element index
      logic       wide_src;  // full 128-bit operand visible
      logic [4:0] dst;
   } dec_t;

   localparam logic [8:0] OPC_MID = 9'b001110000;
   localparam logic [5:0] OPC_LOW = 6'b001111;

endpackage

// File: rtl/vext_decode.sv
module vext_decode
   import vext_pkg::*;
#(
   parameter int INSN_W = 32,
   parameter int REG_W  = 5
) (
   input  logic [INSN_W-1:0] insn,
   output dec_t              dec,
   output logic [REG_W-1:0]  src_reg
);

   localparam int IMM_LO = 16;
   localparam int IMM_W  = 5;

   if (INSN_W != 32) begin : g_bad_insn_w
      $error("vext_decode: INSN_W must be 32");
   end
   if (REG_W != 5) begin : g_bad_reg_w
      $error("vext_decode: REG_W must be 5");
   end

   logic [IMM_W-1:0] imm;
   logic             q_bit;
   logic             size_none;
   esz_e             size;
   logic [3:0]       lane;
   logic             pair_bad;

   assign imm     = insn[IMM_LO +: IMM_W];
   assign q_bit   = insn[30];
   assign src_reg = insn[9:5];

   always_comb begin
      size_none = 1'b0;
      size      = ESZ_8;
      casez (imm[3:0])
         4'b???1: size = ESZ_8;
         4'b??10: size = ESZ_16;
         4'b?100: size = ESZ_32;
         4'b1000: size = ESZ_64;
         default: size_none = 1'b1;
      endcase
   end

   always_comb begin
      unique case (size)
         ESZ_8:   lane = imm[4:1];
         ESZ_16:  lane = {1'b0, imm[4:2]};
         ESZ_32:  lane = {2'b00, imm[4:3]};
         default: lane = {3'b000, imm[4]};
      endcase
   end

   assign pair_bad = q_bit ? (size != ESZ_64) : (size == ESZ_64);

   always_comb begin
      dec.hit      = (insn[31] == 1'b0) && (insn[29:21] == OPC_MID) &&
                     (insn[15:10] == OPC_LOW);
      dec.bad_enc  = size_none || pair_bad;
      dec.narrow   = ~q_bit;
      dec.size     = size;
      dec.lane     = lane;
      dec.wide_src = imm[4];
      dec.dst      = insn[4:0];
   end

endmodule

// File: rtl/vext_select.sv
module vext_select
   import vext_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int XLEN  = 64
) (
   input  logic [VEC_W-1:0] opnd,
   input  logic             wide_src,
   input  esz_e             size,
   input  logic [3:0]       lane,
   input  logic             narrow,
   output logic [XLEN-1:0]  value
);

   localparam int HALF_W = VEC_W / 2;
   localparam int NSIZE  = 4;

   if (VEC_W != 2 * XLEN) begin : g_bad_vec_w
      $error("vext_select: VEC_W must be twice XLEN");
   end
   if (XLEN != 64) begin : g_bad_xlen
      $error("vext_select: XLEN must be 64");
   end

   logic [VEC_W-1:0] window;
   logic [XLEN-1:0]  ext [NSIZE];
   logic [XLEN-1:0]  picked;

   // High half hidden when the index field cannot reach it
   assign window = wide_src ? opnd : {{HALF_W{1'b0}}, opnd[HALF_W-1:0]};

   for (genvar g = 0; g < NSIZE; g++) begin : g_size
      localparam int ESZ = 8 << g;
      localparam int NL  = VEC_W / ESZ;
      localparam int IW  = $clog2(NL);
      logic [ESZ-1:0] lanes [NL];
      for (genvar k = 0; k < NL; k++) begin : g_lane
         assign lanes[k] = window[k*ESZ +: ESZ];
      end
      if (ESZ < XLEN) begin : g_pad
         assign ext[g] = {{(XLEN-ESZ){1'b0}}, lanes[lane[IW-1:0]]};
      end else begin : g_full
         assign ext[g] = lanes[lane[IW-1:0]];
      end
   end

   // Fixed-depth mux: every size path is always evaluated
   assign picked = ext[size];
   assign value  = narrow ? {{(XLEN-32){1'b0}}, picked[31:0]} : picked;

endmodule

// File: rtl/vext_permit.sv
module vext_permit (
   input  logic       hit,
   input  logic       bad_enc,
   input  logic [3:0] lane,
   input  logic       fp_ok,
   input  logic       simd_ok,
   output logic       undef_o,
   output logic       trap_o,
   output logic       wen_o
);

   logic needed_ok;

   assign needed_ok = (lane == 4'd0) ? fp_ok : simd_ok;
   assign undef_o   = hit && bad_enc;
   assign trap_o    = hit && !bad_enc && !needed_ok;
   assign wen_o     = hit && !bad_enc && needed_ok;

endmodule

// File: rtl/vext_to_scalar.sv
module vext_to_scalar
   import vext_pkg::*;
#(
   parameter int INSN_W = 32,
   parameter int VEC_W  = 128,
   parameter int XLEN   = 64,
   parameter int REG_W  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] insn,
   input  logic [VEC_W-1:0]  vec_opnd,
   input  logic              fp_ok,
   input  logic              simd_ok,
   output logic [REG_W-1:0]  src_vreg,
   output logic              out_valid,
   output logic [REG_W-1:0]  out_rd,
   output logic [XLEN-1:0]   out_wdata,
   output logic              out_wen,
   output logic              out_narrow,
   output logic              out_undef,
   output logic              out_trap
);

   dec_t            dec;
   logic [XLEN-1:0] value;
   logic            undef_c, trap_c, wen_c, take;

   vext_decode #(.INSN_W(INSN_W), .REG_W(REG_W)) decode_i (
      .insn    (insn),
      .dec     (dec),
      .src_reg (src_vreg)
   );

   vext_select #(.VEC_W(VEC_W), .XLEN(XLEN)) select_i (
      .opnd     (vec_opnd),
      .wide_src (dec.wide_src),
      .size     (dec.size),
      .lane     (dec.lane),
      .narrow   (dec.narrow),
      .value    (value)
   );

   vext_permit permit_i (
      .hit     (dec.hit),
      .bad_enc (dec.bad_enc),
      .lane    (dec.lane),
      .fp_ok   (fp_ok),
      .simd_ok (simd_ok),
      .undef_o (undef_c),
      .trap_o  (trap_c),
      .wen_o   (wen_c)
   );

   assign take = in_valid && dec.hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_rd     <= '0;
         out_wdata  <= '0;
         out_wen    <= 1'b0;
         out_narrow <= 1'b0;
         out_undef  <= 1'b0;
         out_trap   <= 1'b0;
      end else begin
         out_valid  <= take;
         out_rd     <= take ? dec.dst : '0;
         out_wdata  <= (take && wen_c) ? value : '0;
         out_wen    <= take && wen_c;
         out_narrow <= take && wen_c && dec.narrow;
         out_undef  <= take && undef_c;
         out_trap   <= take && trap_c;
      end
   end

   logic port_hit;
   assign port_hit = (insn[31] == 1'b0) && (insn[29:21] == OPC_MID) &&
                     (insn[15:10] == OPC_LOW);

   // R1
   nomatch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !port_hit) |=> (!out_valid && !out_wen && !out_undef && !out_trap));

   // R4
   reserved_undef_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && port_hit && insn[19:16] == 4'b0000) |=> (out_undef && !out_wen));

   // R5
   wide_pair_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && port_hit && insn[30] && insn[19:16] != 4'b1000) |=> (out_undef && !out_wen));

   // R6
   narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (out_wen && out_narrow) |-> (out_wdata[XLEN-1:32] == '0));

   // R7
   trap_no_write_chk: assert property (@(posedge clk) disable iff (rst)
      out_trap |-> (!out_wen && out_wdata == '0));

   // R8
   undef_trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(out_undef && out_trap));

   // R9
   idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

endmodule

// File: tb/vext_to_scalar_tb.sv
module vext_to_scalar_tb_top;

   localparam logic [127:0] OPND = 128'h7F6E5D4C3B2A1908_F7E6D5C4B3A29180;

   typedef struct packed {
      logic        q;
      logic [4:0]  imm5;
      logic [1:0]  mg;     // 0 intact, 1 set bit 31, 2 break low opcode field
      logic        fp;
      logic        simd;
      logic        ev, eu, et, ew, en;
      logic [63:0] ed;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 5'b00001, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h80},               // R2 R7 byte 0, only fp needed
      '{1'b0, 5'b11111, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h7F},               // R3 top byte
      '{1'b0, 5'b10011, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h19},               // R3 byte 9
      '{1'b0, 5'b00110, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'hB3A2},             // R2 half 1
      '{1'b0, 5'b11110, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h7F6E},             // R3 half 7
      '{1'b0, 5'b01100, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'hF7E6D5C4},         // R6 word 1
      '{1'b0, 5'b10100, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h3B2A1908},         // R3 word 2
      '{1'b1, 5'b01000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 64'hF7E6D5C4B3A29180}, // R6 dword 0
      '{1'b1, 5'b11000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 64'h7F6E5D4C3B2A1908}, // R3 dword 1
      '{1'b0, 5'b10000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0},                // R4 reserved
      '{1'b1, 5'b00001, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0},                // R5 byte into 64
      '{1'b1, 5'b00100, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0},                // R5 word into 64
      '{1'b0, 5'b01000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0},                // R5 dword into 32
      '{1'b0, 5'b00001, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0},                // R7 idx0 fp off
      '{1'b0, 5'b00011, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0},                // R7 idx1 simd off
      '{1'b0, 5'b00011, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h91},               // R7 idx1 simd on
      '{1'b1, 5'b00001, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0},                // R8 undef over trap
      '{1'b0, 5'b00001, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0},                // R1 bit 31 set
      '{1'b0, 5'b00001, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0},                // R1 low field wrong
      '{1'b1, 5'b11000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0},                // R7 dword idx1 trap
      '{1'b0, 5'b00010, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h9180}              // R2 half 0
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [31:0]  insn = '0;
   logic [127:0] vec_opnd = OPND;
   logic         fp_ok = 1'b0;
   logic         simd_ok = 1'b0;
   logic [4:0]   src_vreg, out_rd;
   logic         out_valid, out_wen, out_narrow, out_undef, out_trap;
   logic [63:0]  out_wdata;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   vext_to_scalar dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
      .vec_opnd(vec_opnd), .fp_ok(fp_ok), .simd_ok(simd_ok),
      .src_vreg(src_vreg), .out_valid(out_valid), .out_rd(out_rd),
      .out_wdata(out_wdata), .out_wen(out_wen), .out_narrow(out_narrow),
      .out_undef(out_undef), .out_trap(out_trap)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 5000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: act=%0d cycles exp<=5000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [31:0] mk(input logic q, input logic [4:0] imm5,
                                      input logic [4:0] rn, input logic [4:0] rd);
      return {1'b0, q, 9'b001110000, imm5, 6'b001111, rn, rd};
   endfunction

   function automatic logic [73:0] outs();
      return {out_valid, out_undef, out_trap, out_wen, out_narrow, out_rd, out_wdata};
   endfunction

   task automatic chk(input string tag, input logic [73:0] act, input logic [73:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [31:0] w, input logic f, input logic s);
      @(negedge clk);
      in_valid = 1'b1;
      insn     = w;
      fp_ok    = f;
      simd_ok  = s;
   endtask

   initial begin
      // R10 reset state
      @(negedge clk);
      @(negedge clk);
      chk("R10 state during reset", outs(), '0);
      rst = 1'b0;
      @(negedge clk);
      chk("R10 state after reset", outs(), '0);

      for (int i = 0; i < NV; i++) begin
         logic [31:0] w;
         w = mk(TBL[i].q, TBL[i].imm5, 5'd7, i[4:0]);
         if (TBL[i].mg == 2'd1) w[31] = 1'b1;
         if (TBL[i].mg == 2'd2) w[10] = 1'b0;
         issue(w, TBL[i].fp, TBL[i].simd);
         @(negedge clk);
         in_valid = 1'b0;
         chk($sformatf("table vector %0d", i), outs(),
             {TBL[i].ev, TBL[i].eu, TBL[i].et, TBL[i].ew, TBL[i].en,
              (TBL[i].ev ? i[4:0] : 5'd0), TBL[i].ed});
      end

      // R9 source field brought out, and idle input gives no result
      insn = mk(1'b0, 5'b00001, 5'd22, 5'd4);
      #1;
      chk("R9 src_vreg", {69'd0, src_vreg}, {69'd0, 5'd22});
      @(negedge clk);
      chk("R9 idle no valid", outs(), '0);

      // R9 back-to-back issue, one cycle each
      issue(mk(1'b0, 5'b00111, 5'd1, 5'd9), 1'b1, 1'b1);   // byte 3 via imm5[3:1]=011
      issue(mk(1'b1, 5'b11000, 5'd1, 5'd10), 1'b1, 1'b1);
      chk("R9 back-to-back first", outs(), {5'b10011, 5'd9, 64'hB3});
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 back-to-back second", outs(), {5'b10010, 5'd10, 64'h7F6E5D4C3B2A1908});

      // R3 operand with high half nonzero but unreachable: low-half index only
      vec_opnd = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0};
      issue(mk(1'b0, 5'b01111, 5'd1, 5'd2), 1'b1, 1'b1);   // byte 7
      @(negedge clk);
      in_valid = 1'b0;
      chk("R3 low-half byte 7", outs(), {5'b10011, 5'd2, 64'h0});
      vec_opnd = OPND;

      // R10 reset while an instruction is issued
      issue(mk(1'b0, 5'b00001, 5'd1, 5'd3), 1'b1, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R10 reset mid traffic", outs(), '0);
      rst = 1'b0;
      @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule